// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier Unit

This unit forms integer products for seven operating modes on a single signed 17-bit by 17-bit multiply array. Before an operand reaches the array it is widened to 17 bits: sign extension when the mode treats it as signed, zero extension when the mode treats it as unsigned. Because of this, every combination of operand signs shares the same signed array. Two 16-bit operands, a 5-bit literal and a 3-bit mode code arrive together with a start strobe. The 32-bit product and a valid strobe are registered and appear one clock later.

A caller raises `start` for one cycle with the operands and the mode. On the following cycle `valid` is high and `product` holds the result. `product` keeps that value until the next `start`. Mode codes: 0 signed×signed, 1 unsigned×unsigned, 2 unsigned A × signed B, 3 signed A × unsigned B, 4 unsigned A × literal, 5 signed A × literal, 6 byte×byte unsigned, 7 reserved.

Top module: `mixmul_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `valid` is 0 and `product` is 0.
- R2: `valid` is 1 in exactly the cycle after a cycle in which `start` was 1, and 0 in every other cycle.
- R3: In a cycle after one with `start` low, `product` keeps its previous value, whatever happens on `opa`, `opb`, `lit` and `mode`.
- R4: Mode 0 gives the two's-complement product of `opa` and `opb`, both taken as signed 16-bit values (0x8000 × 0x8000 = 0x40000000).
- R5: Mode 1 gives the product of `opa` and `opb`, both taken as unsigned (0xFFFF × 0xFFFF = 0xFFFE0001).
- R6: Mode 2 gives unsigned `opa` times signed `opb`, as a 32-bit two's-complement value.
- R7: Mode 3 gives signed `opa` times unsigned `opb`, as a 32-bit two's-complement value.
- R8: Mode 4 gives unsigned `opa` times the zero-extended `lit`. Mode 5 gives signed `opa` times the zero-extended `lit`. `opb` has no effect in either mode.
- R9: Mode 6 multiplies `opa[7:0]` by `opb[7:0]`, both unsigned. The upper bytes of the operands are ignored, and `product[31:16]` is 0.
- R10: Mode 7 gives a product of 0 and still raises `valid`. In modes 0 to 3, `lit` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a multiply with the current inputs |
| mode | input | 3 | Operation code, 0 to 7 |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| lit | input | 5 | Unsigned literal, used in modes 4 and 5 |
| product | output | 32 | Registered product |
| valid | output | 1 | High for one cycle when `product` is new |

## Verification
The only state is the output register and the valid flag. A fault therefore appears at the ports in the cycle right after `start`. A wrong extension choice shows up only when an operand has its top bit set, so each mode is tested with 0x8000 and 0xFFFF patterns, where a sign error changes the upper half of the product. Stale or spurious updates are exposed by changing the inputs while `start` is low and confirming that `product` and `valid` stay still.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  parameter int OPW   = 16;
  parameter int LITW  = 5;
  parameter int BYTEW = 8;
  parameter int COREW = OPW + 1;
  parameter int PRODW = 2 * OPW;

  typedef enum logic [2:0] {
    MD_SS   = 3'd0,
    MD_UU   = 3'd1,
    MD_US   = 3'd2,
    MD_SU   = 3'd3,
    MD_LITU = 3'd4,
    MD_LITS = 3'd5,
    MD_BYTE = 3'd6,
    MD_RSVD = 3'd7
  } mul_mode_e;
endpackage

// File: rtl/mixmul_widen.sv
// Extends an IN_W-bit operand to OUT_W bits, sign or zero fill per request.
module mixmul_widen #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 17
) (
  input  logic [IN_W-1:0]         din,
  input  logic                    is_signed,
  output logic signed [OUT_W-1:0] dout
);
  localparam int FILL_W = OUT_W - IN_W;

  logic fill_bit;
  assign fill_bit = is_signed & din[IN_W-1];

  generate
    if (FILL_W > 0) begin : g_fill
      assign dout = {{FILL_W{fill_bit}}, din};
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/mixmul_core.sv
// Shared signed array; both inputs are already widened.
module mixmul_core #(
  parameter int W     = 17,
  parameter int OUT_W = 32
) (
  input  logic signed [W-1:0]     a,
  input  logic signed [W-1:0]     b,
  output logic signed [OUT_W-1:0] p
);
  logic signed [OUT_W-1:0] a_x, b_x;
  assign a_x = OUT_W'(a);
  assign b_x = OUT_W'(b);
  assign p   = a_x * b_x;
endmodule

// File: rtl/mixmul_select.sv
// Picks the raw operands and the signedness of each for the current mode.
module mixmul_select
  import mixmul_pkg::*;
(
  input  mul_mode_e          mode,
  input  logic [OPW-1:0]     opa,
  input  logic [OPW-1:0]     opb,
  input  logic [LITW-1:0]    lit,
  output logic [OPW-1:0]     sel_a,
  output logic [OPW-1:0]     sel_b,
  output logic               a_sgn,
  output logic               b_sgn
);
  localparam int LIT_PAD  = OPW - LITW;
  localparam int BYTE_PAD = OPW - BYTEW;

  always_comb begin
    sel_a = opa;
    sel_b = opb;
    a_sgn = 1'b0;
    b_sgn = 1'b0;
    unique case (mode)
      MD_SS: begin
        a_sgn = 1'b1;
        b_sgn = 1'b1;
      end
      MD_UU: ;
      MD_US: b_sgn = 1'b1;
      MD_SU: a_sgn = 1'b1;
      MD_LITU: sel_b = {{LIT_PAD{1'b0}}, lit};
      MD_LITS: begin
        a_sgn = 1'b1;
        sel_b = {{LIT_PAD{1'b0}}, lit};
      end
      MD_BYTE: begin
        sel_a = {{BYTE_PAD{1'b0}}, opa[BYTEW-1:0]};
        sel_b = {{BYTE_PAD{1'b0}}, opb[BYTEW-1:0]};
      end
      default: begin
        sel_a = '0;
        sel_b = '0;
      end
    endcase
  end
endmodule

// File: rtl/mixmul_unit.sv
module mixmul_unit
  import mixmul_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic [OPW-1:0]   opa,
  input  logic [OPW-1:0]   opb,
  input  logic [LITW-1:0]  lit,
  output logic [PRODW-1:0] product,
  output logic             valid
);
  mul_mode_e             mode_e;
  logic [OPW-1:0]        sel_a, sel_b;
  logic                  a_sgn, b_sgn;
  logic signed [COREW-1:0] wa, wb;
  logic signed [PRODW-1:0] p_comb;

  assign mode_e = mul_mode_e'(mode);

  mixmul_select u_sel (
    .mode  (mode_e),
    .opa   (opa),
    .opb   (opb),
    .lit   (lit),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .a_sgn (a_sgn),
    .b_sgn (b_sgn)
  );

  mixmul_widen #(.IN_W(OPW), .OUT_W(COREW)) u_wa (
    .din (sel_a), .is_signed (a_sgn), .dout (wa)
  );

  mixmul_widen #(.IN_W(OPW), .OUT_W(COREW)) u_wb (
    .din (sel_b), .is_signed (b_sgn), .dout (wb)
  );

  mixmul_core #(.W(COREW), .OUT_W(PRODW)) u_core (
    .a (wa), .b (wb), .p (p_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= start;
      if (start) product <= p_comb;
    end
  end
endmodule

// File: rtl/mixmul_chk.sv
module mixmul_chk
  import mixmul_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       mode,
  input logic [PRODW-1:0] product,
  input logic             valid
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!valid && product == '0)); // R1
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !start |=> !valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(product)); // R3
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 3'd6) |=> (product[PRODW-1:PRODW/2] == '0)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 3'd7) |=> (product == '0)); // R10
endmodule

bind mixmul_unit mixmul_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mode    (mode),
  .product (product),
  .valid   (valid)
);

// File: tb/mixmul_unit_tb.sv
module mixmul_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  mode;
  logic [15:0] opa, opb;
  logic [4:0]  lit;
  logic [31:0] product;
  logic        valid;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mixmul_unit dut_i (
    .clk (clk), .rst (rst), .start (start), .mode (mode),
    .opa (opa), .opb (opb), .lit (lit), .product (product), .valid (valid)
  );

  function automatic logic [31:0] model(input logic [2:0] m, input logic [15:0] a,
                                        input logic [15:0] b, input logic [4:0] l);
    longint sa, ua, sb, ub, ul, r;
    sa = longint'($signed(a)); ua = longint'(a);
    sb = longint'($signed(b)); ub = longint'(b);
    ul = longint'(l);
    case (m)
      3'd0: r = sa * sb;
      3'd1: r = ua * ub;
      3'd2: r = ua * sb;
      3'd3: r = sa * ub;
      3'd4: r = ua * ul;
      3'd5: r = sa * ul;
      3'd6: r = longint'(a[7:0]) * longint'(b[7:0]);
      default: r = 0;
    endcase
    return r[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One launch; sample valid and product at the negedge after the capturing edge.
  task automatic run_op(input string req, input logic [2:0] m, input logic [15:0] a,
                        input logic [15:0] b, input logic [4:0] l);
    @(negedge clk);
    start = 1'b1; mode = m; opa = a; opb = b; lit = l;
    @(negedge clk);
    start = 1'b0;
    check({req, " valid"}, {31'b0, valid}, 32'd1);
    check(req, product, model(m, a, b, l));
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; mode = 3'd0; opa = 16'hFFFF; opb = 16'hFFFF; lit = 5'h1F;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, valid}, 32'd0);
    check("R1 product", product, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {31'b0, valid}, 32'd0);
    check("R1 product after release", product, 32'd0);
  endtask

  task automatic t_signed();
    run_op("R4 8000x8000", 3'd0, 16'h8000, 16'h8000, 5'd0);
    check("R4 literal value", product, 32'h40000000);
    run_op("R4 8000x7FFF", 3'd0, 16'h8000, 16'h7FFF, 5'd0);
    run_op("R10 lit ignored in mode 0", 3'd0, 16'hFFFF, 16'h0003, 5'h1F);
  endtask

  task automatic t_unsigned();
    run_op("R5 FFFFxFFFF", 3'd1, 16'hFFFF, 16'hFFFF, 5'd0);
    check("R5 literal value", product, 32'hFFFE0001);
    run_op("R5 mid", 3'd1, 16'h1234, 16'hABCD, 5'd7);
  endtask

  task automatic t_mixed();
    run_op("R6 FFFFx8000", 3'd2, 16'hFFFF, 16'h8000, 5'd0);
    check("R6 literal value", product, 32'h80008000);
    run_op("R6 8000xFFFF", 3'd2, 16'h8000, 16'hFFFF, 5'd0);
    run_op("R7 8000xFFFF", 3'd3, 16'h8000, 16'hFFFF, 5'd0);
    check("R7 literal value", product, 32'h80008000);
    run_op("R7 FFFFx8000", 3'd3, 16'hFFFF, 16'h8000, 5'd3);
  endtask

  task automatic t_literal();
    run_op("R8 unsigned lit", 3'd4, 16'hFFFF, 16'h5A5A, 5'd31);
    check("R8 unsigned lit value", product, 32'h001EFFE1);
    run_op("R8 signed lit", 3'd5, 16'h8000, 16'hFFFF, 5'd31);
    check("R8 signed lit value", product, 32'hFFF08000);
    run_op("R8 lit zero", 3'd5, 16'h1234, 16'h7777, 5'd0);
  endtask

  task automatic t_byte();
    run_op("R9 upper bytes ignored", 3'd6, 16'hABFF, 16'hCDFF, 5'd9);
    check("R9 value", product, 32'h0000FE01);
    run_op("R9 small", 3'd6, 16'hFF12, 16'h0034, 5'd0);
  endtask

  task automatic t_reserved();
    run_op("R10 reserved", 3'd7, 16'hFFFF, 16'hFFFF, 5'h1F);
    check("R10 reserved zero", product, 32'd0);
  endtask

  task automatic t_hold_and_strobe();
    logic [31:0] held;
    run_op("R3 setup", 3'd1, 16'h00F0, 16'h0F00, 5'd0);
    held = product;
    @(negedge clk);
    mode = 3'd0; opa = 16'h7FFF; opb = 16'h7FFF; lit = 5'd5;
    check("R2 no valid while idle", {31'b0, valid}, 32'd0);
    repeat (3) @(negedge clk);
    check("R3 product held", product, held);
    check("R2 still idle", {31'b0, valid}, 32'd0);
    // back-to-back launches: valid stays high and product tracks each one
    start = 1'b1; mode = 3'd1; opa = 16'd3; opb = 16'd5;
    @(negedge clk);
    check("R2 b2b first valid", {31'b0, valid}, 32'd1);
    check("R2 b2b first", product, 32'd15);
    mode = 3'd1; opa = 16'd7; opb = 16'd9;
    @(negedge clk);
    start = 1'b0;
    check("R2 b2b second valid", {31'b0, valid}, 32'd1);
    check("R2 b2b second", product, 32'd63);
    @(negedge clk);
    check("R2 drops after b2b", {31'b0, valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_signed();
    t_unsigned();
    t_mixed();
    t_literal();
    t_byte();
    t_reserved();
    t_hold_and_strobe();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule